// File: doc/BRIEF.md
# Key-Protected Watchdog Register Front End

This block is the register front end of a watchdog timer. It holds an 8-bit up-counter, an 8-bit control/status byte and a reset-control group. The reset-control group has three bits: an overflow flag, a reset-enable bit and a reset-select bit. Software can change these only through full 16-bit writes. In each write, the upper byte is a key and the lower byte carries the data. Byte-wide stores to the block's addresses are dropped.

Two word addresses are decoded. At offset 0x74, the key picks the target: key 0x5A loads the counter and key 0xA5 loads the control/status byte. At offset 0x76, key 0x5A updates the reset-enable and reset-select bits. At the same offset, key 0xA5 with a zero lower byte clears the overflow flag. Each of these two operations leaves the other's bits untouched.

The counter advances on a one-cycle count-enable pulse while the timer-enable bit is set. When it wraps, it raises the overflow flag. If reset is enabled, it also issues a one-cycle reset request, and the reset-select bit is presented as the reset type.

Top module: `wdt_keyed_regs`

## Requirements
- R1: A write with `bus_word_i` low (byte access) changes no register, at either address.
- R2: A word write to offset 0x74 with upper byte 0x5A loads the lower byte into the counter. The new value is visible on the cycle after the write.
- R3: A word write to offset 0x74 with upper byte 0xA5 loads the lower byte into the control/status byte. Bit 5 of that byte is the timer-enable bit.
- R4: A word write to offset 0x76 with upper byte 0x5A copies lower-byte bit 6 into reset-enable and bit 5 into reset-select, and leaves the overflow flag as it was.
- R5: A word write to offset 0x76 with upper byte 0xA5 and lower byte 0x00 clears the overflow flag and leaves reset-enable and reset-select as they were.
- R6: Any other write changes no register. This covers a word write whose upper byte is neither key, a 0xA5 write to 0x76 with a nonzero lower byte, and a write to any other offset.
- R7: On a cycle with `tick_i` high and timer-enable set, the counter increments by one. With timer-enable clear, or with no tick, it holds.
- R8: A counter step from 0xFF to 0x00 sets the overflow flag. If that set and an overflow-clear write fall in the same cycle, the flag ends up set.
- R9: A keyed counter load in the same cycle as a tick wins over the increment. It never causes a wrap or an overflow.
- R10: `rst_req_o` is high for exactly the one cycle in which the overflow flag has just been set by a wrap while reset-enable was 1. `rst_type_o` always equals reset-select.
- R11: Reset (`rst_n` low) clears the counter, the control/status byte, the overflow flag, reset-enable, reset-select and the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr_i | input | 8 | Local byte offset of the write |
| bus_wdata_i | input | 16 | Write data: key in [15:8], data in [7:0] |
| tick_i | input | 1 | Count-enable pulse (prescaled clock stand-in) |
| cnt_o | output | 8 | Current counter value |
| csr_o | output | 8 | Control/status byte; bit 5 is timer-enable |
| ovf_o | output | 1 | Overflow flag |
| rst_en_o | output | 1 | Reset-enable bit |
| rst_sel_o | output | 1 | Reset-select bit |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_type_o | output | 1 | Reset type, equal to reset-select |

## Verification
The hardest case to reach is a collision in a single cycle. A wrap must coincide with an overflow-clear write, or a counter load must coincide with a tick while the counter holds 0xFF. From the ports, the counter first has to be loaded with 0xFF and the timer enabled. Only then can the colliding write and tick be issued together. Directed sequences set up both cases explicitly. A random phase then keeps reloading the counter with values close to 0xFF, so that wraps keep meeting keyed writes of every kind, and checks each cycle against a behavioural model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = BUS_W / 2;

    typedef struct packed {
        logic              ld_cnt;
        logic              ld_csr;
        logic              ld_rbits;
        logic              clr_ovf;
        logic [BYTE_W-1:0] data;
    } wdt_strobe_t;

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import wdt_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFS_SHARED = 8'h74,
    parameter logic [ADDR_W-1:0] OFS_RCTL   = 8'h76,
    parameter logic [BYTE_W-1:0] KEY_LOAD   = 8'h5A,
    parameter logic [BYTE_W-1:0] KEY_ALT    = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              word_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output wdt_strobe_t       strb_o
);

    logic [BYTE_W-1:0] key;
    logic [BYTE_W-1:0] lo;
    logic              word_wr;
    logic              hit_shared;
    logic              hit_rctl;

    always_comb begin
        key        = wdata_i[BUS_W-1:BYTE_W];
        lo         = wdata_i[BYTE_W-1:0];
        word_wr    = wr_i && word_i;
        hit_shared = word_wr && (addr_i == OFS_SHARED);
        hit_rctl   = word_wr && (addr_i == OFS_RCTL);

        strb_o          = '0;
        strb_o.data     = lo;
        strb_o.ld_cnt   = hit_shared && (key == KEY_LOAD);
        strb_o.ld_csr   = hit_shared && (key == KEY_ALT);
        strb_o.ld_rbits = hit_rctl   && (key == KEY_LOAD);
        strb_o.clr_ovf  = hit_rctl   && (key == KEY_ALT) && (lo == '0);
    end

    // R1: byte accesses never produce a register strobe
    p_byte_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !word_i) |-> !(strb_o.ld_cnt || strb_o.ld_csr || strb_o.ld_rbits || strb_o.clr_ovf));

    // R6: at most one target per write
    p_single_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strb_o.ld_cnt, strb_o.ld_csr, strb_o.ld_rbits, strb_o.clr_ovf}));

endmodule

// File: rtl/wdt_up_counter.sv
module wdt_up_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             tick_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d   = st_q;
        step   = tick_i && run_i && !ld_i;
        wrap_o = step && (st_q.cnt == CNT_MAX);
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R2: keyed load is visible next cycle
    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_o == $past(ld_val_i)));

    // R7: without tick or load the counter holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ld_i) |=> $stable(cnt_o));

    // R9: a load in the same cycle never produces a wrap
    p_load_beats_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |-> !wrap_o);

endmodule

// File: rtl/wdt_csr_bank.sv
module wdt_csr_bank
    import wdt_pkg::*;
#(
    parameter int EN_BIT   = 5,
    parameter int RENA_BIT = 6,
    parameter int RSEL_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wdt_strobe_t       strb_i,
    input  logic              wrap_i,
    output logic [BYTE_W-1:0] csr_o,
    output logic              run_o,
    output logic              ovf_o,
    output logic              rst_en_o,
    output logic              rst_sel_o,
    output logic              rst_req_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] csr;
        logic              ovf;
        logic              rst_en;
        logic              rst_sel;
        logic              req;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (strb_i.ld_csr) begin
            st_d.csr = strb_i.data;
        end
        if (strb_i.ld_rbits) begin
            st_d.rst_en  = strb_i.data[RENA_BIT];
            st_d.rst_sel = strb_i.data[RSEL_BIT];
        end
        if (wrap_i) begin
            st_d.ovf = 1'b1;
            st_d.req = st_q.rst_en;
        end else if (strb_i.clr_ovf) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_o     = st_q.csr;
    assign run_o     = st_q.csr[EN_BIT];
    assign ovf_o     = st_q.ovf;
    assign rst_en_o  = st_q.rst_en;
    assign rst_sel_o = st_q.rst_sel;
    assign rst_req_o = st_q.req;

    // R8: a wrap always leaves the flag set, even against a clear
    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> ovf_o);

    // R5: overflow clear leaves the reset bits alone
    p_clear_keeps_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strb_i.clr_ovf |=> ($stable(rst_en_o) && $stable(rst_sel_o)));

    // R4: reset-bit write leaves the flag alone
    p_rbits_keep_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_i.ld_rbits && !wrap_i && !strb_i.clr_ovf) |=> $stable(ovf_o));

    // R10: request only with the flag set, and never two cycles running
    p_req_needs_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ovf_o);
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R3: control byte only changes on its keyed write
    p_csr_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_i.ld_csr |=> $stable(csr_o));

endmodule

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
    import wdt_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_SHARED = 8'h74,
    parameter logic [ADDR_W-1:0] OFS_RCTL   = 8'h76,
    parameter logic [BYTE_W-1:0] KEY_LOAD   = 8'h5A,
    parameter logic [BYTE_W-1:0] KEY_ALT    = 8'hA5,
    parameter int                EN_BIT     = 5,
    parameter int                RENA_BIT   = 6,
    parameter int                RSEL_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_word_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    input  logic              tick_i,
    output logic [BYTE_W-1:0] cnt_o,
    output logic [BYTE_W-1:0] csr_o,
    output logic              ovf_o,
    output logic              rst_en_o,
    output logic              rst_sel_o,
    output logic              rst_req_o,
    output logic              rst_type_o
);

    wdt_strobe_t strb;
    logic        wrap;
    logic        run;

    wdt_key_decode #(
        .ADDR_W     (ADDR_W),
        .OFS_SHARED (OFS_SHARED),
        .OFS_RCTL   (OFS_RCTL),
        .KEY_LOAD   (KEY_LOAD),
        .KEY_ALT    (KEY_ALT)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .word_i  (bus_word_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .strb_o  (strb)
    );

    wdt_up_counter #(
        .CNT_W (BYTE_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (strb.ld_cnt),
        .ld_val_i (strb.data),
        .tick_i   (tick_i),
        .run_i    (run),
        .cnt_o    (cnt_o),
        .wrap_o   (wrap)
    );

    wdt_csr_bank #(
        .EN_BIT   (EN_BIT),
        .RENA_BIT (RENA_BIT),
        .RSEL_BIT (RSEL_BIT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_i    (strb),
        .wrap_i    (wrap),
        .csr_o     (csr_o),
        .run_o     (run),
        .ovf_o     (ovf_o),
        .rst_en_o  (rst_en_o),
        .rst_sel_o (rst_sel_o),
        .rst_req_o (rst_req_o)
    );

    assign rst_type_o = rst_sel_o;

    // R10: the type output follows the select bit
    p_type_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (rst_type_o == rst_sel_o));

endmodule

// File: tb/wdt_keyed_regs_bench.sv
module wdt_keyed_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        word = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        tick = 1'b0;
    logic [7:0]  cnt, csr;
    logic        ovf, ren, rsel, req, rtype;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt = 0, m_csr = 0, m_ovf = 0, m_en = 0, m_sel = 0, m_req = 0;

    always #2.5 clk = ~clk;

    wdt_keyed_regs u_wdt_keyed_regs (
        .clk (clk), .rst_n (rst_n), .bus_wr_i (wr), .bus_word_i (word),
        .bus_addr_i (addr), .bus_wdata_i (wdata), .tick_i (tick),
        .cnt_o (cnt), .csr_o (csr), .ovf_o (ovf), .rst_en_o (ren),
        .rst_sel_o (rsel), .rst_req_o (req), .rst_type_o (rtype)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_csr = 0; m_ovf = 0; m_en = 0; m_sel = 0; m_req = 0;
        end else begin
            int hi, lo, running, set;
            bit w;
            hi = wdata[15:8];
            lo = wdata[7:0];
            w  = wr && word;
            running = (m_csr / 32) % 2;
            set = 0;
            m_req = 0;
            if (w && addr == 8'h74 && hi == 8'h5A) m_cnt = lo;
            else if (tick && running == 1) begin
                if (m_cnt == 255) begin m_cnt = 0; set = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (w && addr == 8'h74 && hi == 8'hA5) m_csr = lo;
            if (set == 1) begin
                m_req = m_en;
                m_ovf = 1;
            end else if (w && addr == 8'h76 && hi == 8'hA5 && lo == 0) m_ovf = 0;
            if (w && addr == 8'h76 && hi == 8'h5A) begin
                m_en  = (lo / 64) % 2;
                m_sel = (lo / 32) % 2;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 counter vs model", cnt, m_cnt);
            chk("R3 csr vs model", csr, m_csr);
            chk("R8 overflow vs model", ovf, m_ovf);
            chk("R4 reset-enable vs model", ren, m_en);
            chk("R4 reset-select vs model", rsel, m_sel);
            chk("R10 request vs model", req, m_req);
            chk("R10 type vs select", rtype, m_sel);
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d,
                             input logic w, input logic t);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d; word = w; tick = t;
        @(negedge clk);
        wr = 1'b0; word = 1'b0; tick = 1'b0; wdata = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R11 actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 counter after reset", cnt, 0);
        chk("R11 csr after reset", csr, 0);
        chk("R11 ovf after reset", ovf, 0);
        chk("R11 req after reset", req, 0);

        bus_write(8'h74, 16'h5A3C, 1'b1, 1'b0);
        chk("R2 counter load", cnt, 8'h3C);
        bus_write(8'h74, 16'h5A11, 1'b0, 1'b0);
        chk("R1 byte write to counter", cnt, 8'h3C);
        bus_write(8'h76, 16'h5A60, 1'b0, 1'b0);
        chk("R1 byte write to reset bits", ren, 0);
        bus_write(8'h74, 16'hA520, 1'b1, 1'b0);
        chk("R3 csr load", csr, 8'h20);
        ticks(3);
        chk("R7 three ticks", cnt, 8'h3F);
        bus_write(8'h74, 16'hA500, 1'b1, 1'b0);
        ticks(2);
        chk("R7 ticks while disabled", cnt, 8'h3F);

        bus_write(8'h76, 16'h5A60, 1'b1, 1'b0);
        chk("R4 reset-enable set", ren, 1);
        chk("R4 reset-select set", rsel, 1);
        bus_write(8'h74, 16'h5AFE, 1'b1, 1'b0);
        bus_write(8'h74, 16'hA520, 1'b1, 1'b0);
        ticks(1);
        chk("R8 no flag before wrap", ovf, 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R8 wrap to zero", cnt, 0);
        chk("R8 flag on wrap", ovf, 1);
        chk("R10 request on wrap", req, 1);
        chk("R10 type on wrap", rtype, 1);
        @(negedge clk);
        chk("R10 request one cycle", req, 0);

        bus_write(8'h76, 16'h5A20, 1'b1, 1'b0);
        chk("R4 enable cleared", ren, 0);
        chk("R4 flag kept", ovf, 1);
        bus_write(8'h76, 16'hA501, 1'b1, 1'b0);
        chk("R6 nonzero clear pattern", ovf, 1);
        bus_write(8'h76, 16'h3C00, 1'b1, 1'b0);
        chk("R6 wrong key", ovf, 1);
        bus_write(8'h70, 16'hA500, 1'b1, 1'b0);
        chk("R6 other offset", ovf, 1);
        bus_write(8'h76, 16'hA500, 1'b1, 1'b0);
        chk("R5 flag cleared", ovf, 0);
        chk("R5 select kept", rsel, 1);
        chk("R5 enable kept", ren, 0);

        bus_write(8'h74, 16'h5AFF, 1'b1, 1'b0);
        bus_write(8'h76, 16'hA500, 1'b1, 1'b1);
        chk("R8 set beats clear", ovf, 1);
        chk("R10 no request when disabled", req, 0);
        bus_write(8'h76, 16'hA500, 1'b1, 1'b0);
        bus_write(8'h74, 16'h5AFF, 1'b1, 1'b0);
        bus_write(8'h74, 16'h5A10, 1'b1, 1'b1);
        chk("R9 load wins over tick", cnt, 8'h10);
        chk("R9 no overflow from load", ovf, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            @(negedge clk);
            wr   = r[0];
            word = r[1] | r[2];
            case (r[4:3])
                2'd0: addr = 8'h70;
                2'd1: addr = 8'h74;
                default: addr = 8'h76;
            endcase
            case (r[6:5])
                2'd0: wdata[15:8] = 8'h00;
                2'd1: wdata[15:8] = 8'hA5;
                default: wdata[15:8] = 8'h5A;
            endcase
            if (r[9:7] == 3'd0) wdata[7:0] = 8'h00;
            else if (r[9:7] < 3'd4) wdata[7:0] = 8'hFC | r[11:10];
            else wdata[7:0] = r[19:12];
            tick = r[20] | r[21];
        end
        @(negedge clk);
        wr = 1'b0; word = 1'b0; tick = 1'b0;
        @(negedge clk);

        done = 1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 counter mid-run reset", cnt, 0);
        chk("R11 csr mid-run reset", csr, 0);
        chk("R11 flag mid-run reset", ovf, 0);
        chk("R11 enable mid-run reset", ren, 0);
        chk("R11 select mid-run reset", rsel, 0);
        chk("R11 request mid-run reset", req, 0);
        summary();
        $finish;
    end

endmodule